// File: doc/BRIEF.md
# Link Sync Monitor for Balanced 10-bit Code Groups

This block watches a stream of 10-bit code groups that are already word-aligned, and decides whether a serial link is alive. A cable that is unplugged or an input left floating produces groups that break the rules of a DC-balanced line code. The monitor finds those groups, so that logic downstream can switch off the channel and discard what it sends.

Each group is checked in three ways. The first is the count of ones in the group. The second is the running disparity carried from group to group. The third is the length of runs of identical bits, and these runs are counted across group boundaries. The results come out as three per-group flags, one clock after the group is accepted. A small lock machine starts in a hunting state. It moves to lock when a comma group arrives. In lock it absorbs a limited number of bad groups and falls back to hunting when that limit is passed. While it is locked, `link_up` is high.

Top module: `lsm_link_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `link_up`, `flag_valid`, `code_error`, `disparity_error` and `run_error` are all 0.
- R2: A group presented with `grp_valid` high at one rising edge makes `flag_valid` high after that edge, and its flags appear at the same time. On a cycle that follows an edge with `grp_valid` low, `flag_valid` and all three flags are 0.
- R3: `code_error` is set for a group whose count of ones is anything other than 4, 5 or 6.
- R4: The running disparity is negative after reset. A group with six ones while the disparity is positive, or with four ones while it is negative, sets `disparity_error`; a code-error group never does. A legal group with six ones makes the disparity positive, one with four ones makes it negative, one with five leaves it alone, and a code-error group leaves it unchanged.
- R5: Bit 9 of `grp` is the first bit on the wire and bit 0 the last. A run of more than `MAX_RUN` (default 4) identical bits sets `run_error`. Runs are counted across group boundaries, and after reset there is no earlier bit to carry in. A comma group never sets `run_error`, but its bits still feed the run count.
- R6: While hunting, a comma group sets `link_up` after that group's edge. A comma group is either 0011111010 or 1100000101, written bit 9 down to bit 0. Acquiring lock also forces the running disparity to negative.
- R7: A bad group is one that raises any of the three flags. While locked, a bad group raises the bad count if the count is below `BAD_TOL` (default 2). A bad group that arrives when the count already equals `BAD_TOL` drops `link_up` and returns the block to hunting.
- R8: While locked, a good group lowers the bad count by one, and the count never goes below zero.
- R9: While hunting, groups that are not commas, and cycles with no valid group, keep `link_up` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A code group is presented this cycle |
| grp | input | 10 | Aligned code group, bit 9 first on the wire |
| flag_valid | output | 1 | The flags below belong to the group accepted at the last edge |
| code_error | output | 1 | The group's count of ones is illegal |
| disparity_error | output | 1 | The group breaks the running disparity |
| run_error | output | 1 | A run of identical bits is too long |
| link_up | output | 1 | The monitor is locked |

## Verification
The bench first sends every one of the 1024 group values back to back. Every result is compared with a reference model, so both comma forms, the balanced groups and the unbalanced groups are all seen from both disparity states, with run lengths carried in from the group before. A design that counted runs inside each group only would miss a fault that spans two groups. A design that did not exempt the comma would flag every acquisition. A design that let code-error groups change the disparity would produce false disparity errors later in the stream.

The directed part then tests the tolerance at its exact edge. Two bad groups are sent and the third must drop the link, so an off-by-one counter gives up one group early or one group late. A good-bad mix checks that the count goes down but never wraps below zero. Without that floor, a later pair of bad groups would either drop the link too soon or be tolerated too long.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int GW = 10;
  localparam logic [GW-1:0] COMMA_RDN = 10'b0011111010;
  localparam logic [GW-1:0] COMMA_RDP = 10'b1100000101;

  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} sync_state_t;

  function automatic logic is_comma(logic [GW-1:0] g);
    return (g == COMMA_RDN) || (g == COMMA_RDP);
  endfunction

  function automatic logic [3:0] ones_of(logic [GW-1:0] g);
    logic [3:0] s;
    s = 4'd0;
    for (int i = 0; i < GW; i++) s = s + {3'd0, g[i]};
    return s;
  endfunction
endpackage

// File: rtl/lsm_balance.sv
module lsm_balance
  import lsm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_valid,
  input  logic [GW-1:0] grp,
  input  logic          acq,
  output logic          code_err,
  output logic          disp_err,
  output logic          rd_pos
);
  logic [3:0] ones;
  logic       heavy, light;

  assign ones     = ones_of(grp);
  assign code_err = (ones < 4'd4) || (ones > 4'd6);
  assign heavy    = (ones == 4'd6);
  assign light    = (ones == 4'd4);
  assign disp_err = !code_err && ((heavy && rd_pos) || (light && !rd_pos));

  always_ff @(posedge clk) begin
    if (!rst_n) rd_pos <= 1'b0;
    else if (grp_valid) begin
      if (acq)            rd_pos <= 1'b0;
      else if (!code_err) begin
        if (heavy)        rd_pos <= 1'b1;
        else if (light)   rd_pos <= 1'b0;
      end
    end
  end

  assert_rd_neg_after_acq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && acq) |=> !rd_pos);
  assert_rd_heavy_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !acq && !code_err && heavy) |=> rd_pos);
  assert_rd_hold_on_code_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !acq && code_err) |=> (rd_pos == $past(rd_pos)));
endmodule

// File: rtl/lsm_runlen.sv
module lsm_runlen
  import lsm_pkg::*;
#(
  parameter int MAX_RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_valid,
  input  logic [GW-1:0] grp,
  input  logic          exempt,
  output logic          run_err
);
  localparam int LW = $clog2(MAX_RUN + 2);
  localparam logic [LW-1:0] SAT = LW'(MAX_RUN + 1);

  logic          carry_bit;
  logic [LW-1:0] carry_len;
  logic          end_bit;
  logic [LW-1:0] end_len;
  logic          hit;

  // walk the group in wire order, continuing the run left by the previous group
  always_comb begin
    end_bit = carry_bit;
    end_len = carry_len;
    hit     = 1'b0;
    for (int i = GW - 1; i >= 0; i--) begin
      if (end_len != '0 && grp[i] == end_bit) begin
        if (end_len < SAT) end_len = end_len + LW'(1);
      end else begin
        end_len = LW'(1);
      end
      end_bit = grp[i];
      if (end_len > LW'(MAX_RUN)) hit = 1'b1;
    end
  end

  assign run_err = hit && !exempt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_bit <= 1'b0;
      carry_len <= '0;
    end else if (grp_valid) begin
      carry_bit <= end_bit;
      carry_len <= end_len;
    end
  end

  assert_run_spans_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !exempt && carry_len >= LW'(MAX_RUN) && grp[GW-1] == carry_bit) |-> run_err);
  assert_carry_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    carry_len <= SAT);
endmodule

// File: rtl/lsm_sync.sv
module lsm_sync
  import lsm_pkg::*;
#(
  parameter int BAD_TOL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grp_valid,
  input  logic comma,
  input  logic bad,
  output logic acq,
  output logic locked
);
  localparam int CW = $clog2(BAD_TOL + 2);
  localparam logic [CW-1:0] LIMIT = CW'(BAD_TOL);

  sync_state_t   state;
  logic [CW-1:0] bad_cnt;

  assign acq    = grp_valid && (state == ST_HUNT) && comma;
  assign locked = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      bad_cnt <= '0;
    end else if (acq) begin
      state   <= ST_LOCK;
      bad_cnt <= '0;
    end else if (locked && grp_valid) begin
      if (bad) begin
        if (bad_cnt == LIMIT) begin
          state   <= ST_HUNT;
          bad_cnt <= '0;
        end else begin
          bad_cnt <= bad_cnt + CW'(1);
        end
      end else if (bad_cnt != '0) begin
        bad_cnt <= bad_cnt - CW'(1);
      end
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt <= LIMIT);
  assert_drop_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && grp_valid && bad && bad_cnt == LIMIT) |=> !locked);
  assert_acquire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && grp_valid && comma) |=> (locked && bad_cnt == '0));
  assert_hunt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !(grp_valid && comma)) |=> !locked);
  assert_good_decrements_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && grp_valid && !bad && bad_cnt != '0) |=> (bad_cnt == $past(bad_cnt) - CW'(1)));
endmodule

// File: rtl/lsm_link_monitor.sv
module lsm_link_monitor
  import lsm_pkg::*;
#(
  parameter int BAD_TOL = 2,
  parameter int MAX_RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grp_valid,
  input  logic [GW-1:0] grp,
  output logic          flag_valid,
  output logic          code_error,
  output logic          disparity_error,
  output logic          run_error,
  output logic          link_up
);
  logic comma, acq, locked, rd_pos;
  logic code_err, disp_err, run_err, bad;

  assign comma = is_comma(grp);
  assign bad   = code_err || disp_err || run_err;

  lsm_balance u_balance (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp(grp), .acq(acq),
    .code_err(code_err), .disp_err(disp_err), .rd_pos(rd_pos)
  );

  lsm_runlen #(.MAX_RUN(MAX_RUN)) u_runlen (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp(grp), .exempt(comma),
    .run_err(run_err)
  );

  lsm_sync #(.BAD_TOL(BAD_TOL)) u_sync (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .comma(comma), .bad(bad),
    .acq(acq), .locked(locked)
  );

  assign link_up = locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_valid      <= 1'b0;
      code_error      <= 1'b0;
      disparity_error <= 1'b0;
      run_error       <= 1'b0;
    end else begin
      flag_valid      <= grp_valid;
      code_error      <= grp_valid && code_err;
      disparity_error <= grp_valid && disp_err;
      run_error       <= grp_valid && run_err;
    end
  end

  assert_quiet_without_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |=> !(flag_valid || code_error || disparity_error || run_error));
  assert_code_excludes_disp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_error |-> !disparity_error);
  assert_comma_no_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && comma) |=> !run_error);
  assert_flags_imply_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_error || disparity_error || run_error) |-> flag_valid);
endmodule

// File: tb/tb_lsm_link_monitor.sv
module tb_lsm_link_monitor;
  localparam int CLK_P = 10;
  localparam int TOL   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       grp_valid = 1'b0;
  logic [9:0] grp = '0;
  logic       flag_valid, code_error, disparity_error, run_error, link_up;

  int checks = 0;
  int failures = 0;

  // reference state
  bit m_rd;
  bit m_bit;
  int m_len;
  bit m_lock;
  int m_cnt;

  always #(CLK_P/2) clk = ~clk;

  lsm_link_monitor #(.BAD_TOL(TOL), .MAX_RUN(4)) dut (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp(grp),
    .flag_valid(flag_valid), .code_error(code_error),
    .disparity_error(disparity_error), .run_error(run_error), .link_up(link_up)
  );

  task automatic check(bit act, bit exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rd = 0; m_bit = 0; m_len = 0; m_lock = 0; m_cnt = 0;
  endtask

  task automatic send(logic [9:0] g, string ltag);
    int ones, n;
    bit e_code, e_disp, e_run, is_c, b, hit, acq;
    ones = 0;
    for (int i = 0; i < 10; i++) if (g[i]) ones++;
    e_code = (ones < 4) || (ones > 6);
    e_disp = !e_code && ((ones == 6 && m_rd) || (ones == 4 && !m_rd));
    is_c = (g == 10'h0FA) || (g == 10'h305);
    b = m_bit; n = m_len; hit = 0;
    for (int i = 9; i >= 0; i--) begin
      if (n > 0 && g[i] == b) n = (n > 6) ? n : n + 1;
      else n = 1;
      b = g[i];
      if (n > 4) hit = 1;
    end
    e_run = hit && !is_c;
    m_bit = b; m_len = n;
    acq = !m_lock && is_c;
    if (acq) m_rd = 0;
    else if (!e_code) begin
      if (ones == 6) m_rd = 1;
      else if (ones == 4) m_rd = 0;
    end
    if (acq) begin m_lock = 1; m_cnt = 0; end
    else if (m_lock) begin
      if (e_code || e_disp || e_run) begin
        if (m_cnt == TOL) begin m_lock = 0; m_cnt = 0; end
        else m_cnt++;
      end else if (m_cnt > 0) m_cnt--;
    end
    grp_valid = 1'b1; grp = g;
    @(posedge clk);
    @(negedge clk);
    grp_valid = 1'b0;
    check(flag_valid, 1'b1, "R2", $sformatf("flag_valid grp=%03h", g));
    check(code_error, e_code, "R3", $sformatf("code_error grp=%03h", g));
    check(disparity_error, e_disp, "R4", $sformatf("disparity_error grp=%03h", g));
    check(run_error, e_run, "R5", $sformatf("run_error grp=%03h", g));
    check(link_up, m_lock, ltag, $sformatf("link_up grp=%03h", g));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; grp_valid = 1'b0;
    @(negedge clk);
    check(link_up, 1'b0, "R1", "link_up in reset");
    check(flag_valid, 1'b0, "R1", "flag_valid in reset");
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check(link_up, 1'b0, "R1", "link_up after reset");
    check(code_error | disparity_error | run_error, 1'b0, "R1", "flags after reset");
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();

    // R9: idle hunting, balanced non-comma groups never lock
    for (int k = 0; k < 4; k++) send(10'h2AA, "R9");

    // R2: a cycle with no valid group leaves flags low
    @(posedge clk); @(negedge clk);
    check(flag_valid, 1'b0, "R2", "flag_valid idle");
    check(code_error | disparity_error | run_error, 1'b0, "R2", "flags idle");

    // full sweep of all group values back to back (R3 R4 R5 R6 R7)
    for (int v = 0; v < 1024; v++) send(10'(v), "R6");

    // R7: two bad tolerated, third drops
    do_reset();
    send(10'h0FA, "R6");
    send(10'h2AA, "R6");
    send(10'h000, "R7");
    send(10'h2AA, "R7");  // good: count back to 0 (R8)
    send(10'h000, "R7");
    send(10'h000, "R7");
    send(10'h000, "R7");

    // R8: decrement and floor at zero
    send(10'h305, "R6");
    send(10'h000, "R8");
    send(10'h2AA, "R8");
    send(10'h2AA, "R8");
    send(10'h2AA, "R8");
    send(10'h000, "R8");
    send(10'h000, "R8");
    send(10'h2AA, "R8");
    send(10'h000, "R8");
    send(10'h000, "R8");

    // R6: other comma form after loss, then R9 hunting with bad groups
    send(10'h3FF, "R9");
    send(10'h305, "R6");
    send(10'h0FA, "R6");
    send(10'h2AA, "R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule